// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register File

This block is the control-register front end of an audio codec. It sits on a plain 32-bit word bus with a 64-byte window. Sixteen 32-bit words are addressed directly. Behind them sit thirty-two 8-bit registers that software reaches indirectly. The low five bits of direct word 0 act as a pointer, and direct word 1 is the data window onto the register that the pointer names.

Several locations have their own rules:
- One indirect slot always reads as zero.
- Two indirect slots hold fixed identification values and ignore writes.
- One indirect slot keeps a single writable bit and holds a fixed identification pattern in the others.
- Direct word 2 discards what is written to it.
- Direct word 4 is a control word that stores only its low seven bits. Writing it with bit 0 set returns the whole register file to its reset contents, while the masked control value is still stored.

The interrupt output exists for integration and is held low.

Top module: `codec_ctl_regs`

## Requirements
- R1: After a synchronous active-high reset every direct word reads 0. Every indirect register reads 0, except index 12, which reads 0x8A, and index 25, which reads 0xA0.
- R2: The word selected is byte address bits [5:2]. A write to any word other than 1, 2 and 4 stores all 32 bits, and a read of that word returns them. This includes the upper bits of word 0.
- R3: The indirect pointer is bits [4:0] of direct word 0. A read of word 1 returns the selected 8-bit register zero-extended to 32 bits, and a write to word 1 updates the selected register.
- R4: Index 3 always reads as 0 through word 1, even after it has been written.
- R5: Writes to indexes 11 and 25 are ignored. They keep reading 0x00 and 0xA0.
- R6: A write to index 12 stores (wdata[7:0] & 0x40) | 0x8A.
- R7: Writes to direct word 2 are discarded, and word 2 reads 0.
- R8: A write to word 4 with bit 0 set restores every register to its R1 value. In the same cycle, word 4 stores wdata & 0x7F.
- R9: A write to word 4 with bit 0 clear stores wdata & 0x7F and leaves the other registers unchanged.
- R10: The interrupt output is always 0.
- R11: A write becomes visible from the rising clock edge on which bus_wr is sampled high. Read data follows the address and the current state combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address within the window |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request, held low |

## Verification
The bench targets the pointer path and the special slots behind it:
- **Zero-read slot:** index 3 is written with all ones. A design that forgot the hole would read back 0xFF.
- **Locked identification slots:** both are written. A missing lock would lose 0xA0 or expose the written byte.
- **Merge slot:** this slot is driven with patterns that both set and clear bit 6. A wrong mask would leak other bits or drop the constant.
- **Control word:** it is written once with bit 0 clear and once with bit 0 set. A design that cleared word 4 after storing it, stored it unmasked, or reset on bit 0 clear would show it at the ports.
- **Write timing:** the bench checks that a write is not yet visible before the sampling edge.

// File: rtl/cdc_regs_pkg.sv
package cdc_regs_pkg;

    localparam int CDC_DATA_W   = 32;
    localparam int CDC_NUM_DIR  = 16;
    localparam int CDC_NUM_IND  = 32;
    localparam int CDC_IND_W    = 8;

    localparam int WIN_WORD     = 1;
    localparam int DROP_WORD    = 2;
    localparam int CTRL_WORD    = 4;
    localparam int CTRL_KEEP    = 'h7F;

    localparam int HOLE_IDX     = 3;
    localparam int LOCK_IDX     = 11;
    localparam int MERGE_IDX    = 12;
    localparam int VER_IDX      = 25;
    localparam int MERGE_KEEP   = 'h40;
    localparam int MERGE_ID     = 'h8A;
    localparam int VER_ID       = 'hA0;

    typedef enum logic [1:0] {
        W_PLAIN,
        W_WINDOW,
        W_DROP,
        W_CTRL
    } word_kind_e;

    typedef enum logic [1:0] {
        I_PLAIN,
        I_LOCKED,
        I_MERGE
    } ind_kind_e;

    function automatic word_kind_e word_kind(input int i);
        case (i)
            WIN_WORD:  return W_WINDOW;
            DROP_WORD: return W_DROP;
            CTRL_WORD: return W_CTRL;
            default:   return W_PLAIN;
        endcase
    endfunction

    function automatic ind_kind_e ind_kind(input int i);
        if (i == LOCK_IDX || i == VER_IDX) return I_LOCKED;
        if (i == MERGE_IDX)                return I_MERGE;
        return I_PLAIN;
    endfunction

    function automatic int ind_reset(input int i);
        if (i == MERGE_IDX) return MERGE_ID;
        if (i == VER_IDX)   return VER_ID;
        return 0;
    endfunction

    function automatic logic [CDC_IND_W-1:0] merge_byte(input logic [CDC_IND_W-1:0] d);
        return (d & CDC_IND_W'(MERGE_KEEP)) | CDC_IND_W'(MERGE_ID);
    endfunction

endpackage

// File: rtl/cdc_direct_bank.sv
module cdc_direct_bank
    import cdc_regs_pkg::*;
#(
    parameter int NUM_DIRECT = CDC_NUM_DIR,
    parameter int DATA_W     = CDC_DATA_W,
    localparam int WORD_AW   = $clog2(NUM_DIRECT)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr,
    input  logic [WORD_AW-1:0]                 word,
    input  logic [DATA_W-1:0]                  wdata,
    output logic                               soft_rst,
    output logic [NUM_DIRECT-1:0][DATA_W-1:0]  dir_q
);

    assign soft_rst = wr && (word == WORD_AW'(CTRL_WORD)) && wdata[0];

    for (genvar i = 0; i < NUM_DIRECT; i++) begin : g_word
        localparam word_kind_e KIND = word_kind(i);
        if (KIND == W_WINDOW || KIND == W_DROP) begin : g_none
            assign dir_q[i] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wr && word == WORD_AW'(i))
                    q <= (KIND == W_CTRL) ? (wdata & DATA_W'(CTRL_KEEP)) : wdata;
                else if (soft_rst)
                    q <= '0;
            end
            assign dir_q[i] = q;
        end
    end

    p_ctrl_store_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && word == WORD_AW'(CTRL_WORD)) |=>
            dir_q[CTRL_WORD] == ($past(wdata) & DATA_W'(CTRL_KEEP)));

    p_soft_clear_r8: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> dir_q[0] == '0);

endmodule

// File: rtl/cdc_indirect_bank.sv
module cdc_indirect_bank
    import cdc_regs_pkg::*;
#(
    parameter int NUM_IND   = CDC_NUM_IND,
    parameter int IND_W     = CDC_IND_W,
    localparam int IND_AW   = $clog2(NUM_IND)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           soft_rst,
    input  logic                           wr,
    input  logic [IND_AW-1:0]              idx,
    input  logic [IND_W-1:0]               wdata,
    output logic [NUM_IND-1:0][IND_W-1:0]  ind_q
);

    for (genvar i = 0; i < NUM_IND; i++) begin : g_ind
        localparam ind_kind_e KIND = ind_kind(i);
        localparam logic [IND_W-1:0] RST_VAL = IND_W'(ind_reset(i));
        if (KIND == I_LOCKED) begin : g_locked
            assign ind_q[i] = RST_VAL;
        end else begin : g_reg
            logic [IND_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst || soft_rst)
                    q <= RST_VAL;
                else if (wr && idx == IND_AW'(i))
                    q <= (KIND == I_MERGE) ? merge_byte(wdata) : wdata;
            end
            assign ind_q[i] = q;
        end
    end

    p_merge_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && !soft_rst && idx == IND_AW'(MERGE_IDX)) |=>
            ind_q[MERGE_IDX] == (($past(wdata) & IND_W'(MERGE_KEEP)) | IND_W'(MERGE_ID)));

    p_soft_defaults_r8: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ind_q[MERGE_IDX] == IND_W'(MERGE_ID)) && (ind_q[0] == '0));

endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
    import cdc_regs_pkg::*;
#(
    parameter int NUM_DIRECT = CDC_NUM_DIR,
    parameter int NUM_IND    = CDC_NUM_IND,
    parameter int DATA_W     = CDC_DATA_W,
    parameter int IND_W      = CDC_IND_W,
    localparam int WORD_AW   = $clog2(NUM_DIRECT),
    localparam int IND_AW    = $clog2(NUM_IND),
    localparam int BUS_AW    = WORD_AW + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [WORD_AW-1:0]                word;
    logic [IND_AW-1:0]                 idx;
    logic                              soft_rst;
    logic                              win_wr;
    logic [NUM_DIRECT-1:0][DATA_W-1:0] dir_q;
    logic [NUM_IND-1:0][IND_W-1:0]     ind_q;

    assign word   = bus_addr[BUS_AW-1:2];
    assign idx    = dir_q[0][IND_AW-1:0];
    assign win_wr = bus_wr && (word == WORD_AW'(WIN_WORD));
    assign irq    = 1'b0;

    cdc_direct_bank #(
        .NUM_DIRECT (NUM_DIRECT),
        .DATA_W     (DATA_W)
    ) u_direct (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .word     (word),
        .wdata    (bus_wdata),
        .soft_rst (soft_rst),
        .dir_q    (dir_q)
    );

    cdc_indirect_bank #(
        .NUM_IND (NUM_IND),
        .IND_W   (IND_W)
    ) u_indirect (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr       (win_wr),
        .idx      (idx),
        .wdata    (bus_wdata[IND_W-1:0]),
        .ind_q    (ind_q)
    );

    always_comb begin
        if (word == WORD_AW'(WIN_WORD))
            bus_rdata = (idx == IND_AW'(HOLE_IDX)) ? '0 : DATA_W'(ind_q[idx]);
        else
            bus_rdata = dir_q[word];
    end

    p_hole_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (word == WORD_AW'(WIN_WORD) && idx == IND_AW'(HOLE_IDX)) |-> bus_rdata == '0);

    p_drop_word_r7: assert property (@(posedge clk) disable iff (rst)
        (word == WORD_AW'(DROP_WORD)) |-> bus_rdata == '0);

    p_window_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (word == WORD_AW'(WIN_WORD)) |-> bus_rdata[DATA_W-1:IND_W] == '0);

endmodule

// File: tb/test_codec_ctl_regs.sv
module test_codec_ctl_regs;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    codec_ctl_regs i_codec_ctl_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr_word(input int w, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 6'(w * 4);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd_word(input int w, output logic [31:0] d);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = 6'(w * 4);
        #1 d = bus_rdata;
    endtask

    task automatic wr_ind(input int i, input logic [7:0] d);
        wr_word(0, 32'(i));
        wr_word(1, {24'h0, d});
    endtask

    task automatic rd_ind(input int i, output logic [31:0] d);
        wr_word(0, 32'(i));
        rd_word(1, d);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd_word(0, v);  check("R1 word0", v, 32'h0);
        rd_word(4, v);  check("R1 word4", v, 32'h0);
        rd_word(15, v); check("R1 word15", v, 32'h0);
        rd_word(1, v);  check("R1 ind0", v, 32'h0);
        rd_ind(12, v);  check("R1 ind12", v, 32'h8A);
        rd_ind(25, v);  check("R1 ind25", v, 32'hA0);
        rd_ind(31, v);  check("R1 ind31", v, 32'h0);
        check("R10 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_direct;
        logic [31:0] v;
        wr_word(5, 32'hDEADBEEF);
        wr_word(15, 32'h12345678);
        rd_word(5, v);  check("R2 word5", v, 32'hDEADBEEF);
        rd_word(15, v); check("R2 word15", v, 32'h12345678);
        wr_word(0, 32'hABCDE007);
        rd_word(0, v);  check("R2 word0 upper kept", v, 32'hABCDE007);
    endtask

    task automatic t_timing;
        @(negedge clk);
        bus_addr  = 6'd24;
        bus_wdata = 32'h000055AA;
        bus_wr    = 1'b1;
        #1 check("R11 before edge", bus_rdata, 32'h0);
        @(posedge clk);
        #1 check("R11 after edge", bus_rdata, 32'h000055AA);
        bus_wr = 1'b0;
    endtask

    task automatic t_indirect;
        logic [31:0] v;
        wr_ind(7, 8'h5A);
        wr_ind(31, 8'hC3);
        rd_ind(7, v);   check("R3 ind7", v, 32'h5A);
        rd_ind(31, v);  check("R3 ind31", v, 32'hC3);
        wr_word(0, 32'hFFFFFF07);
        rd_word(1, v);  check("R3 upper pointer bits ignored", v, 32'h5A);
    endtask

    task automatic t_hole;
        logic [31:0] v;
        wr_ind(3, 8'hFF);
        rd_word(1, v);  check("R4 ind3 reads zero", v, 32'h0);
    endtask

    task automatic t_locked;
        logic [31:0] v;
        wr_ind(11, 8'h77);
        rd_word(1, v);  check("R5 ind11 locked", v, 32'h0);
        wr_ind(25, 8'h11);
        rd_word(1, v);  check("R5 ind25 locked", v, 32'hA0);
    endtask

    task automatic t_merge;
        logic [31:0] v;
        wr_ind(12, 8'hFF); rd_word(1, v); check("R6 ff", v, 32'hCA);
        wr_ind(12, 8'h00); rd_word(1, v); check("R6 00", v, 32'h8A);
        wr_ind(12, 8'h40); rd_word(1, v); check("R6 40", v, 32'hCA);
        wr_ind(12, 8'hBF); rd_word(1, v); check("R6 bf", v, 32'h8A);
    endtask

    task automatic t_drop;
        logic [31:0] v;
        wr_word(2, 32'hFFFFFFFF);
        rd_word(2, v);  check("R7 word2 discarded", v, 32'h0);
    endtask

    task automatic t_ctrl_plain;
        logic [31:0] v;
        wr_word(5, 32'h0BADF00D);
        wr_ind(7, 8'h5A);
        wr_word(4, 32'hFFFFFF7E);
        rd_word(4, v);  check("R9 ctrl masked", v, 32'h7E);
        rd_word(5, v);  check("R9 word5 kept", v, 32'h0BADF00D);
        rd_word(0, v);  check("R9 pointer kept", v, 32'h7);
        rd_word(1, v);  check("R9 ind7 kept", v, 32'h5A);
    endtask

    task automatic t_soft_reset;
        logic [31:0] v;
        wr_ind(12, 8'h40);
        wr_word(5, 32'hCAFEF00D);
        wr_word(4, 32'h000000A3);
        rd_word(4, v);  check("R8 ctrl kept masked", v, 32'h23);
        rd_word(5, v);  check("R8 word5 cleared", v, 32'h0);
        rd_word(0, v);  check("R8 pointer cleared", v, 32'h0);
        rd_word(6, v);  check("R8 word6 cleared", v, 32'h0);
        rd_ind(12, v);  check("R8 ind12 default", v, 32'h8A);
        rd_ind(25, v);  check("R8 ind25 default", v, 32'hA0);
        rd_ind(7, v);   check("R8 ind7 cleared", v, 32'h0);
        check("R10 irq low", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        #40000;
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        bus_addr  = '0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_direct();
        t_timing();
        t_indirect();
        t_hole();
        t_locked();
        t_merge();
        t_drop();
        t_ctrl_plain();
        t_soft_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule